// File: doc/BRIEF.md
# Receive Frame Decoder with Type Detection

This block is the decoding stage on the receive side of a serial point-to-point link. Once per recovered word clock it takes one demultiplexed frame. The frame is 24 bits wide, with a 20-bit data field, or 20 bits wide, with a 16-bit data field. The four most significant bits of the frame form a header. Two bits of that header form a master-transition pair. The polarity of this pair tells the block whether the transmitter complemented the whole frame to keep the line DC-balanced. When it did, the block complements the frame back before decoding anything else.

The restored header sorts each frame into one of three kinds: data, control or fill. The block then drives the restored data word, a flag bit, active-low data-valid and control-valid strobes, the fill type and an error flag. A header with no master transition is reported as an error and handled like a fill frame. When the flag bit is not carried as user data, the block also checks the unused bits of control and fill frames and reports any violation on the same error output.

Top module: `fdec_top`

## Requirements
- R1: With `wide_i`=1 the frame occupies `frame_i[23:0]`: header in [23:20], data field in [19:0]. With `wide_i`=0 the frame occupies `frame_i[19:0]`: header in [19:16], data field in [15:0]. In the narrow case `frame_i[23:20]` is ignored and `data_o[19:16]` is 0.
- R2: Header bits [2:1] form the master-transition pair. The value 10 marks an upright frame. The value 01 marks an inverted frame, in which case the header and the whole data field are complemented before decoding.
- R3: The restored type code is {header[3], header[0]}. Code 00 or 01 is a data frame: `dav_no`=0, `cav_no`=1, `data_o` equals the data field, and `flag_o` equals header[0].
- R4: Type code 10 is a control frame: `cav_no`=0, `dav_no`=1, `flag_o`=0. `data_o` keeps only the low (data-field width − 2) bits; the two bits above them are 0.
- R5: Type code 11 is a fill frame: `dav_no`=`cav_no`=1, `data_o`=0, `flag_o`=0, and `fill_o` equals bit 0 of the restored data field (0 for the first fill type, 1 for the second).
- R6: A master-transition pair of 00 or 11 is illegal. It sets `err_o`=1, `dav_no`=`cav_no`=1, and `data_o`, `flag_o` and `fill_o` to 0.
- R7: With `flag_data_i`=0, `err_o` is also set by a control frame whose two spare data-field bits are not both 0, and by a fill frame whose restored data field is neither all zeros nor all ones. With `flag_data_i`=1 these two checks are off.
- R8: A frame sampled at clock edge k appears on the outputs after edge k+1. The outputs are reloaded on every clock.
- R9: During and after reset, until the first frame reaches the outputs: `dav_no`=`cav_no`=1, and `data_o`, `flag_o`, `fill_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 24-bit frame, 0: 20-bit frame |
| flag_data_i | input | 1 | 1: flag carried as user data, extra checks off |
| frame_i | input | 24 | Demultiplexed frame |
| data_o | output | 20 | Restored data word |
| flag_o | output | 1 | Flag bit of data frames |
| dav_no | output | 1 | Data frame present, active low |
| cav_no | output | 1 | Control frame present, active low |
| fill_o | output | 1 | Fill type of a fill frame |
| err_o | output | 1 | Illegal header or failed extended check |

## Verification
The block's only state is the input frame register, its valid bit and the output register. A fault in the inversion decision shows up two clocks after the faulty frame enters, as a complemented `data_o` or as the wrong strobe low. A wrong extraction position for either frame width appears in the same cycle as a misread type or as stray upper data bits. A fault in the valid bit or in the reset values shows up in the first cycles after reset, as strobes or an error flag asserted before any frame has arrived.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_CTRL = 2'd1,
    K_FILL = 2'd2,
    K_BAD  = 2'd3
  } kind_e;
endpackage

// File: rtl/fdec_split.sv
module fdec_split #(
  parameter int DW_W = 20,
  parameter int DW_N = 16,
  parameter int HW   = 4,
  localparam int FW  = DW_W + HW
) (
  input  logic [FW-1:0]   frame_i,
  input  logic            wide_i,
  output logic [HW-1:0]   hdr_o,
  output logic [DW_W-1:0] dat_o,
  output logic [DW_W-1:0] mask_o
);
  localparam logic [DW_W-1:0] MASK_N = DW_W'({DW_N{1'b1}});

  always_comb begin
    if (wide_i) begin
      hdr_o  = frame_i[FW-1 -: HW];
      dat_o  = frame_i[DW_W-1:0];
      mask_o = '1;
    end else begin
      hdr_o  = frame_i[DW_N+HW-1 -: HW];
      dat_o  = DW_W'(frame_i[DW_N-1:0]);
      mask_o = MASK_N;
    end
  end
endmodule

// File: rtl/fdec_classify.sv
module fdec_classify
  import fdec_pkg::*;
#(
  parameter int DW_W  = 20,
  parameter int HW    = 4,
  parameter int SPARE = 2
) (
  input  logic [HW-1:0]   hdr_i,
  input  logic [DW_W-1:0] dat_i,
  input  logic [DW_W-1:0] mask_i,
  input  logic            flag_data_i,
  output kind_e           kind_o,
  output logic [DW_W-1:0] data_o,
  output logic            flag_o,
  output logic            fill_o,
  output logic            err_o
);
  localparam int MT_HI = HW - 2;
  localparam int MT_LO = HW - 3;

  logic            legal, inv, xchk;
  logic [HW-1:0]   rh;
  logic [DW_W-1:0] rd, cmask;

  assign legal = hdr_i[MT_HI] ^ hdr_i[MT_LO];
  assign inv   = hdr_i[MT_LO];                 // pair 01 => frame was complemented
  assign rh    = hdr_i ^ {HW{inv}};
  assign rd    = (dat_i ^ {DW_W{inv}}) & mask_i;
  assign cmask = mask_i >> SPARE;
  assign xchk  = ~flag_data_i;

  always_comb begin
    kind_o = K_BAD;
    data_o = '0;
    flag_o = 1'b0;
    fill_o = 1'b0;
    err_o  = 1'b1;
    if (legal) begin
      err_o = 1'b0;
      unique case ({rh[HW-1], rh[0]})
        2'b00, 2'b01: begin
          kind_o = K_DATA;
          data_o = rd;
          flag_o = rh[0];
        end
        2'b10: begin
          kind_o = K_CTRL;
          data_o = rd & cmask;
          err_o  = xchk && ((rd & ~cmask) != '0);
        end
        default: begin
          kind_o = K_FILL;
          fill_o = rd[0];
          err_o  = xchk && (rd != (rd[0] ? mask_i : '0));
        end
      endcase
    end
  end
endmodule

// File: rtl/fdec_top.sv
module fdec_top
  import fdec_pkg::*;
#(
  parameter int DW_W  = 20,
  parameter int DW_N  = 16,
  parameter int HW    = 4,
  parameter int SPARE = 2,
  localparam int FW   = DW_W + HW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wide_i,
  input  logic            flag_data_i,
  input  logic [FW-1:0]   frame_i,
  output logic [DW_W-1:0] data_o,
  output logic            flag_o,
  output logic            dav_no,
  output logic            cav_no,
  output logic            fill_o,
  output logic            err_o
);
  logic [FW-1:0]   s1_frame;
  logic            s1_vld;
  logic [HW-1:0]   hdr;
  logic [DW_W-1:0] dat, mask, c_data;
  logic            c_flag, c_fill, c_err;
  kind_e           c_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_frame <= '0;
      s1_vld   <= 1'b0;
    end else begin
      s1_frame <= frame_i;
      s1_vld   <= 1'b1;
    end
  end

  fdec_split #(.DW_W(DW_W), .DW_N(DW_N), .HW(HW)) u_split (
    .frame_i (s1_frame),
    .wide_i  (wide_i),
    .hdr_o   (hdr),
    .dat_o   (dat),
    .mask_o  (mask)
  );

  fdec_classify #(.DW_W(DW_W), .HW(HW), .SPARE(SPARE)) u_cls (
    .hdr_i       (hdr),
    .dat_i       (dat),
    .mask_i      (mask),
    .flag_data_i (flag_data_i),
    .kind_o      (c_kind),
    .data_o      (c_data),
    .flag_o      (c_flag),
    .fill_o      (c_fill),
    .err_o       (c_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      flag_o <= 1'b0;
      dav_no <= 1'b1;
      cav_no <= 1'b1;
      fill_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (s1_vld) begin
      data_o <= c_data;
      flag_o <= c_flag;
      dav_no <= (c_kind != K_DATA);
      cav_no <= (c_kind != K_CTRL);
      fill_o <= c_fill;
      err_o  <= c_err;
    end
  end
endmodule

// File: rtl/fdec_chk.sv
module fdec_chk #(
  parameter int DW_W  = 20,
  parameter int DW_N  = 16,
  parameter int HW    = 4,
  parameter int SPARE = 2,
  localparam int FW   = DW_W + HW
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wide_i,
  input logic            flag_data_i,
  input logic [FW-1:0]   frame_i,
  input logic [DW_W-1:0] data_o,
  input logic            flag_o,
  input logic            dav_no,
  input logic            cav_no,
  input logic            err_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_TYPE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dav_no && !cav_no)); // R3

  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cav_no |-> (data_o[DW_W-1 -: SPARE] == '0) && !flag_o); // R4

  AST_FILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dav_no && cav_no) |-> (data_o == '0) && !flag_o); // R5

  AST_BAD_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(wide_i) && ($past(frame_i[FW-2], 2) == $past(frame_i[FW-3], 2)))
      |-> err_o && dav_no && cav_no); // R6

  AST_BAD_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && !$past(wide_i) &&
     ($past(frame_i[DW_N+HW-2], 2) == $past(frame_i[DW_N+HW-3], 2)))
      |-> err_o && dav_no && cav_no); // R6

  AST_ERR_ONLY_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(flag_data_i)) |-> dav_no && cav_no); // R7

  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wide_i) |-> (data_o[DW_W-1:DW_N] == '0)); // R1
endmodule

bind fdec_top fdec_chk #(.DW_W(DW_W), .DW_N(DW_N), .HW(HW), .SPARE(SPARE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wide_i      (wide_i),
  .flag_data_i (flag_data_i),
  .frame_i     (frame_i),
  .data_o      (data_o),
  .flag_o      (flag_o),
  .dav_no      (dav_no),
  .cav_no      (cav_no),
  .err_o       (err_o)
);

// File: tb/sim_fdec_top.sv
module sim_fdec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide = 1'b1;
  logic        flag_data = 1'b0;
  logic [23:0] frame = '0;
  logic [19:0] data_o;
  logic        flag_o, dav_no, cav_no, fill_o, err_o;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [19:0] data;
    logic        flag, dav_n, cav_n, fill, err;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  fdec_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wide_i(wide), .flag_data_i(flag_data),
    .frame_i(frame), .data_o(data_o), .flag_o(flag_o), .dav_no(dav_no),
    .cav_no(cav_no), .fill_o(fill_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // builds a frame from a restored type code, data field and polarity
  function automatic logic [23:0] mk(bit w, logic [1:0] t, logic [19:0] d, bit inv, logic [3:0] top);
    logic [3:0]  h;
    logic [23:0] f;
    logic [19:0] f20;
    h = {t[1], 1'b1, 1'b0, t[0]};
    if (w) begin
      f = {h, d};
      if (inv) f = ~f;
    end else begin
      f20 = {h, d[15:0]};
      if (inv) f20 = ~f20;
      f = {top, f20};
    end
    return f;
  endfunction

  task automatic send(input logic [23:0] f, input logic [19:0] ed, input logic ef, ev, ec,
                      efl, ee, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    frame = f;
    e.data = ed; e.flag = ef; e.dav_n = ev; e.cav_n = ec; e.fill = efl; e.err = ee;
    e.due = cyc + 2; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_mode(input bit w, input bit fd);
    repeat (3) @(posedge clk);
    #1;
    wide = w;
    flag_data = fd;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (data_o !== e.data || flag_o !== e.flag || dav_no !== e.dav_n ||
          cav_no !== e.cav_n || fill_o !== e.fill || err_o !== e.err) begin
        misses++;
        $display("FAIL %s: got data=%h flag=%b dav_n=%b cav_n=%b fill=%b err=%b, exp data=%h flag=%b dav_n=%b cav_n=%b fill=%b err=%b",
                 e.tag, data_o, flag_o, dav_no, cav_no, fill_o, err_o,
                 e.data, e.flag, e.dav_n, e.cav_n, e.fill, e.err);
      end
    end
  end

  task automatic chk_reset(input string tag);
    vectors++;
    if (data_o !== '0 || flag_o !== 1'b0 || dav_no !== 1'b1 || cav_no !== 1'b1 ||
        fill_o !== 1'b0 || err_o !== 1'b0) begin
      misses++;
      $display("FAIL %s: got data=%h flag=%b dav_n=%b cav_n=%b fill=%b err=%b, exp 00000 0 1 1 0 0",
               tag, data_o, flag_o, dav_no, cav_no, fill_o, err_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset("R9 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_reset("R9 after release");

    // wide frames, extended checks on
    send(mk(1, 2'b00, 20'hABCDE, 0, 4'h0), 20'hABCDE, 0, 0, 1, 0, 0, "R3 R8 data upright");
    send(mk(1, 2'b01, 20'h12345, 1, 4'h0), 20'h12345, 1, 0, 1, 0, 0, "R2 R3 data inverted flag");
    send(mk(1, 2'b10, 20'h3FFFF, 0, 4'h0), 20'h3FFFF, 0, 1, 0, 0, 0, "R4 control clean");
    send(mk(1, 2'b10, 20'hFFFFF, 1, 4'h0), 20'h3FFFF, 0, 1, 0, 0, 1, "R4 R7 control spare set");
    send(mk(1, 2'b11, 20'h00000, 0, 4'h0), 20'h00000, 0, 1, 1, 0, 0, "R5 fill type 0");
    send(mk(1, 2'b11, 20'hFFFFF, 1, 4'h0), 20'h00000, 0, 1, 1, 1, 0, "R5 R2 fill type 1 inverted");
    send(mk(1, 2'b11, 20'h00010, 0, 4'h0), 20'h00000, 0, 1, 1, 0, 1, "R7 fill mixed");
    send(24'hF00000,                        20'h00000, 0, 1, 1, 0, 1, "R6 pair 11");
    send(24'h9ABCDE,                        20'h00000, 0, 1, 1, 0, 1, "R6 pair 00");

    // flag carried as data: extended checks off
    set_mode(1, 1);
    send(mk(1, 2'b10, 20'hFFFFF, 0, 4'h0), 20'h3FFFF, 0, 1, 0, 0, 0, "R7 control spare ignored");
    send(mk(1, 2'b11, 20'h00011, 0, 4'h0), 20'h00000, 0, 1, 1, 1, 0, "R7 R5 fill mixed ignored");
    send(mk(1, 2'b01, 20'h00000, 0, 4'h0), 20'h00000, 1, 0, 1, 0, 0, "R3 flag as data");

    // narrow frames
    set_mode(0, 0);
    send(mk(0, 2'b00, 20'h0BEEF, 0, 4'hA), 20'h0BEEF, 0, 0, 1, 0, 0, "R1 narrow data");
    send(mk(0, 2'b00, 20'h01234, 1, 4'h5), 20'h01234, 0, 0, 1, 0, 0, "R1 R2 narrow inverted");
    send(mk(0, 2'b10, 20'h0FFFF, 0, 4'hF), 20'h03FFF, 0, 1, 0, 0, 1, "R4 R7 narrow control spare");
    send(mk(0, 2'b10, 20'h00F0F, 0, 4'h3), 20'h00F0F, 0, 1, 0, 0, 0, "R4 narrow control");
    send(mk(0, 2'b11, 20'h0FFFF, 1, 4'hC), 20'h00000, 0, 1, 1, 1, 0, "R5 narrow fill type 1");
    send(24'hA90000,                        20'h00000, 0, 1, 1, 0, 1, "R6 R1 narrow pair 00");
    send(mk(0, 2'b01, 20'h0AAAA, 0, 4'hF), 20'h0AAAA, 1, 0, 1, 0, 0, "R1 R3 narrow flag");

    repeat (4) @(posedge clk);
    if (q.size() != 0) begin
      misses++;
      $display("FAIL R8: got %0d pending, exp 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule